// File: doc/BRIEF.md
# Two-Bank Interrupt Controller Register File

This block gathers forty level-sensitive interrupt sources into a register file that a processor reaches over a simple single-cycle bus. Sources 0 to 31 occupy a 32-bit low bank. Sources 32 to 39 occupy bit positions 0 to 7 of an 8-bit high bank, and the upper bits of that bank read as zero. Each source has an enable bit and a steering bit. The steering bit sends the source to either the fast interrupt output or the normal interrupt output. Software reads the raw pending state and two masked views, one per output.

An idle-wake control decides whether a pending source that is masked may still wake a halted core. Forty priority entries are stored and read back for the separate priority resolver. That resolver's result enters the block on a port and is returned at its own offset. A second, index-based access path reaches the pending, mask, steering and highest-priority registers of both banks as an alias of the main map. On that path only the mask and steering registers are writable.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Source k with k < 32 appears at bit k of every low-bank register. Source k with k >= 32 appears at bit k-32 of the matching high-bank register. High-bank bits 31:8 read as zero, and writes to those bits are dropped.
- R2: The raw pending bit of a source equals the level of its input pin sampled at the previous clock edge. Raw pending sits at offset 0x10 (low bank) and 0xAC (high bank). Writes to either offset have no effect.
- R3: The normal-pending view (0x00 low, 0x9C high) reads pending & enable & ~steer. The fast-pending view (0x0C low, 0xA8 high) reads pending & enable & steer.
- R4: fiqOut is high one cycle after any bit of pending & enable & steer is set. irqOut is high one cycle after any bit of pending & enable & ~steer is set.
- R5: At offset 0x14, a write with bit 0 = 1 clears the idle mask and a write with bit 0 = 0 sets it to all ones. A read returns 1 when the idle mask is clear and 0 otherwise. The idle mask is clear after reset.
- R6: While coreHalted is high, wakeReq is high one cycle after pending & (enable | idle mask) is nonzero. While coreHalted is low, wakeReq is low.
- R7: Priority entries 0 to 31 sit at 0x1C + 4*i, and entries 32 to 39 sit at 0xB0 + 4*(i-32). A write keeps bit 31 and bits 5:0 of the data. All other bits read back as zero.
- R8: Index-path indices 0 to 0xA select, in order: low normal-pending, low mask, low steer, low fast-pending, low raw-pending, highest-priority, then high normal-pending, high mask, high steer, high fast-pending and high raw-pending. Writes take effect only at the mask and steer indices. Other indices read zero and ignore writes. A bus write in the same cycle takes precedence.
- R9: A bus read from an undefined or unaligned offset returns zero, and a write to such an offset changes no state.
- R10: After reset, enable, steering, pending, priority entries and all three outputs are zero.
- R11: Offset 0x18 and index 5 both return the value on hpValue.
- R12: The enable register reads back at 0x04 (low) and 0xA0 (high). The steering register reads back at 0x08 (low) and 0xA4 (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | Bus write when high, read when low |
| busAddr | input | 8 | Bus byte offset |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Bus read data, same cycle |
| cpValid | input | 1 | Index-path access strobe |
| cpWrite | input | 1 | Index-path write when high |
| cpIndex | input | 4 | Index-path register index |
| cpWdata | input | 32 | Index-path write data |
| cpRdata | output | 32 | Index-path read data, same cycle |
| srcLevel | input | 40 | Source pin levels |
| coreHalted | input | 1 | Core is halted |
| hpValue | input | 32 | Result of the external priority resolver |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |
| wakeReq | output | 1 | Wake request to a halted core |

## Verification
A corrupted enable or steering bit sends a source to the wrong output, or to no output. The fault shows on irqOut or fiqOut one cycle after the register changes, and on the masked views in the same cycle they are read. A pending register that fails to track its pin shows in the raw view one edge late, and on the outputs two edges after the pin moves. A wrong idle mask shows on wakeReq one cycle after the idle-control write. A decode fault shows immediately as nonzero data at an undefined offset, or as a register that changes after a write it should have ignored.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_IRQ_VIEW,
    SEL_ENABLE,
    SEL_STEER,
    SEL_FIQ_VIEW,
    SEL_RAW,
    SEL_IDLE,
    SEL_HIGHEST,
    SEL_PRIO
  } regSel_e;

  typedef struct packed {
    regSel_e    sel;
    logic       bank;
    logic [5:0] prioIdx;
  } access_t;

  typedef struct packed {
    logic        enable;
    logic        steer;
    logic        idle;
    logic        prio;
    logic        bank;
    logic [5:0]  prioIdx;
    logic [31:0] data;
  } wrStrobe_t;

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              cpValid,
  input  logic              cpWrite,
  input  logic [IDX_W-1:0]  cpIndex,
  input  logic [DATA_W-1:0] cpWdata,
  output access_t           busAcc,
  output access_t           cpAcc,
  output wrStrobe_t         wrStb
);

  localparam int HI_SRC    = NUM_SRC - 32;
  localparam int PRIO_LO   = 'h1C;
  localparam int PRIO_LO_E = PRIO_LO + 4 * 31;
  localparam int PRIO_HI   = 'hB0;
  localparam int PRIO_HI_E = PRIO_HI + 4 * (HI_SRC - 1);

  function automatic access_t decodeAddr(input logic [ADDR_W-1:0] a);
    access_t r;
    int      ai;
    r  = '{sel: SEL_NONE, bank: 1'b0, prioIdx: 6'd0};
    ai = int'(a);
    if (a[1:0] == 2'b00) begin
      if (ai >= PRIO_LO && ai <= PRIO_LO_E) begin
        r.sel     = SEL_PRIO;
        r.prioIdx = 6'((ai - PRIO_LO) >> 2);
      end else if (ai >= PRIO_HI && ai <= PRIO_HI_E) begin
        r.sel     = SEL_PRIO;
        r.prioIdx = 6'(32 + ((ai - PRIO_HI) >> 2));
      end else begin
        case (ai)
          'h00: r.sel = SEL_IRQ_VIEW;
          'h04: r.sel = SEL_ENABLE;
          'h08: r.sel = SEL_STEER;
          'h0C: r.sel = SEL_FIQ_VIEW;
          'h10: r.sel = SEL_RAW;
          'h14: r.sel = SEL_IDLE;
          'h18: r.sel = SEL_HIGHEST;
          'h9C: begin r.sel = SEL_IRQ_VIEW; r.bank = 1'b1; end
          'hA0: begin r.sel = SEL_ENABLE;   r.bank = 1'b1; end
          'hA4: begin r.sel = SEL_STEER;    r.bank = 1'b1; end
          'hA8: begin r.sel = SEL_FIQ_VIEW; r.bank = 1'b1; end
          'hAC: begin r.sel = SEL_RAW;      r.bank = 1'b1; end
          default: r.sel = SEL_NONE;
        endcase
      end
    end
    return r;
  endfunction

  // Index order is fixed: low bank group, highest-priority, high bank group
  function automatic access_t decodeIndex(input logic [IDX_W-1:0] i);
    access_t r;
    r = '{sel: SEL_NONE, bank: 1'b0, prioIdx: 6'd0};
    case (i)
      4'h0: r.sel = SEL_IRQ_VIEW;
      4'h1: r.sel = SEL_ENABLE;
      4'h2: r.sel = SEL_STEER;
      4'h3: r.sel = SEL_FIQ_VIEW;
      4'h4: r.sel = SEL_RAW;
      4'h5: r.sel = SEL_HIGHEST;
      4'h6: begin r.sel = SEL_IRQ_VIEW; r.bank = 1'b1; end
      4'h7: begin r.sel = SEL_ENABLE;   r.bank = 1'b1; end
      4'h8: begin r.sel = SEL_STEER;    r.bank = 1'b1; end
      4'h9: begin r.sel = SEL_FIQ_VIEW; r.bank = 1'b1; end
      4'hA: begin r.sel = SEL_RAW;      r.bank = 1'b1; end
      default: r.sel = SEL_NONE;
    endcase
    return r;
  endfunction

  logic busWr;
  logic cpWr;

  always_comb begin
    busAcc = decodeAddr(busAddr);
    cpAcc  = decodeIndex(cpIndex);
    busWr  = busValid && busWrite;
    cpWr   = cpValid && cpWrite;
    wrStb  = '0;
    if (busWr) begin
      wrStb.enable  = (busAcc.sel == SEL_ENABLE);
      wrStb.steer   = (busAcc.sel == SEL_STEER);
      wrStb.idle    = (busAcc.sel == SEL_IDLE);
      wrStb.prio    = (busAcc.sel == SEL_PRIO);
      wrStb.bank    = busAcc.bank;
      wrStb.prioIdx = busAcc.prioIdx;
      wrStb.data    = busWdata;
    end else if (cpWr) begin
      wrStb.enable  = (cpAcc.sel == SEL_ENABLE);
      wrStb.steer   = (cpAcc.sel == SEL_STEER);
      wrStb.bank    = cpAcc.bank;
      wrStb.data    = cpWdata;
    end
  end

endmodule

// File: rtl/irq_bank_state.sv
module irq_bank_state
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobe_t          wrStb,
  input  access_t            busAcc,
  input  access_t            cpAcc,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               coreHalted,
  input  logic [DATA_W-1:0]  hpValue,
  output logic [DATA_W-1:0]  busRdata,
  output logic [DATA_W-1:0]  cpRdata,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               wakeReq,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] steerVec,
  output logic               idleAll
);

  localparam int NPORT = 2;
  localparam int PE_W  = PRIO_W + 1;

  logic [NUM_SRC-1:0] pendQ, maskQ, steerQ;
  logic               idleQ;
  logic [PE_W-1:0]    prioQ [NUM_SRC];

  // Level-following pending state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= srcLevel;
  end

  // Enable and steering, written per bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      steerQ <= '0;
    end else begin
      for (int b = 0; b < NUM_SRC; b++) begin
        if ((b >= 32) == wrStb.bank) begin
          if (wrStb.enable) maskQ[b]  <= wrStb.data[b & 31];
          if (wrStb.steer)  steerQ[b] <= wrStb.data[b & 31];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           idleQ <= 1'b0;
    else if (wrStb.idle) idleQ <= ~wrStb.data[0];
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : gPrio
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prioQ[g] <= '0;
        else if (wrStb.prio && wrStb.prioIdx == 6'(g))
          prioQ[g] <= {wrStb.data[DATA_W-1], wrStb.data[PRIO_W-1:0]};
      end
    end
  endgenerate

  // Registered outputs
  logic [NUM_SRC-1:0] live;
  assign live = pendQ & maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut  <= 1'b0;
      fiqOut  <= 1'b0;
      wakeReq <= 1'b0;
    end else begin
      irqOut  <= |(live & ~steerQ);
      fiqOut  <= |(live & steerQ);
      wakeReq <= coreHalted && |(pendQ & (maskQ | {NUM_SRC{idleQ}}));
    end
  end

  function automatic logic [DATA_W-1:0] bankView(input logic [NUM_SRC-1:0] v,
                                                 input logic bank);
    return bank ? DATA_W'(v[NUM_SRC-1:32]) : v[31:0];
  endfunction

  // One read mux per access path
  access_t           accArr [NPORT];
  logic [DATA_W-1:0] rdArr  [NPORT];
  assign accArr[0] = busAcc;
  assign accArr[1] = cpAcc;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : gRead
      always_comb begin
        case (accArr[p].sel)
          SEL_IRQ_VIEW: rdArr[p] = bankView(live & ~steerQ, accArr[p].bank);
          SEL_FIQ_VIEW: rdArr[p] = bankView(live & steerQ, accArr[p].bank);
          SEL_ENABLE:   rdArr[p] = bankView(maskQ, accArr[p].bank);
          SEL_STEER:    rdArr[p] = bankView(steerQ, accArr[p].bank);
          SEL_RAW:      rdArr[p] = bankView(pendQ, accArr[p].bank);
          SEL_IDLE:     rdArr[p] = DATA_W'(!idleQ);
          SEL_HIGHEST:  rdArr[p] = hpValue;
          SEL_PRIO: begin
            rdArr[p] = '0;
            if (int'(accArr[p].prioIdx) < NUM_SRC) begin
              rdArr[p][DATA_W-1]   = prioQ[accArr[p].prioIdx][PE_W-1];
              rdArr[p][PRIO_W-1:0] = prioQ[accArr[p].prioIdx][PRIO_W-1:0];
            end
          end
          default:      rdArr[p] = '0;
        endcase
      end
    end
  endgenerate

  assign busRdata = rdArr[0];
  assign cpRdata  = rdArr[1];
  assign pendVec  = pendQ;
  assign maskVec  = maskQ;
  assign steerVec = steerQ;
  assign idleAll  = idleQ;

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               cpValid,
  input  logic               cpWrite,
  input  logic [IDX_W-1:0]   cpIndex,
  input  logic [DATA_W-1:0]  cpWdata,
  output logic [DATA_W-1:0]  cpRdata,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic               coreHalted,
  input  logic [DATA_W-1:0]  hpValue,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               wakeReq
);

  access_t            busAcc, cpAcc;
  wrStrobe_t          wrStb;
  logic [NUM_SRC-1:0] pendVec, maskVec, steerVec;
  logic               idleAll;

  irq_bank_decode #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_decode (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .cpValid(cpValid), .cpWrite(cpWrite),
    .cpIndex(cpIndex), .cpWdata(cpWdata),
    .busAcc(busAcc), .cpAcc(cpAcc), .wrStb(wrStb)
  );

  irq_bank_state #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)
  ) u_state (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .busAcc(busAcc), .cpAcc(cpAcc),
    .srcLevel(srcLevel), .coreHalted(coreHalted), .hpValue(hpValue),
    .busRdata(busRdata), .cpRdata(cpRdata),
    .irqOut(irqOut), .fiqOut(fiqOut), .wakeReq(wakeReq),
    .pendVec(pendVec), .maskVec(maskVec), .steerVec(steerVec),
    .idleAll(idleAll)
  );

endmodule

// File: rtl/irq_bank_checker.sv
module irq_bank_checker #(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busRdata,
  input logic               cpValid,
  input logic               cpWrite,
  input logic [IDX_W-1:0]   cpIndex,
  input logic [NUM_SRC-1:0] srcLevel,
  input logic               coreHalted,
  input logic               irqOut,
  input logic               fiqOut,
  input logic               wakeReq,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [NUM_SRC-1:0] maskVec,
  input logic [NUM_SRC-1:0] steerVec,
  input logic               idleAll
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  p_pend_follow_r2: assert property (@(posedge clk) disable iff (!rstN || !armed)
    pendVec == $past(srcLevel));

  p_fiq_line_r4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    fiqOut == $past(|(pendVec & maskVec & steerVec)));

  p_irq_line_r4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    irqOut == $past(|(pendVec & maskVec & ~steerVec)));

  p_wake_r6: assert property (@(posedge clk) disable iff (!rstN || !armed)
    wakeReq == $past(coreHalted && |(pendVec & (maskVec | {NUM_SRC{idleAll}}))));

  p_prio_field_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr[1:0] == 2'b00 &&
     busAddr >= ADDR_W'('h1C) && busAddr <= ADDR_W'('h98)) |-> busRdata[30:6] == '0);

  p_cp_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cpValid && cpWrite && cpIndex > IDX_W'('hA) && !(busValid && busWrite))
      |=> ($stable(maskVec) && $stable(steerVec)));

  p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && (busAddr[1:0] != 2'b00 || busAddr > ADDR_W'('hCC)))
      |-> busRdata == '0);

endmodule

bind irq_bank_ctrl irq_bank_checker #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_checker (.*);

// File: tb/test_irq_bank_ctrl.sv
module test_irq_bank_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic        cpValid = 1'b0, cpWrite = 1'b0;
  logic [3:0]  cpIndex = '0;
  logic [31:0] cpWdata = '0, cpRdata;
  logic [39:0] srcLevel = '0;
  logic        coreHalted = 1'b0;
  logic [31:0] hpValue = 32'h8003_0005;
  logic        irqOut, fiqOut, wakeReq;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_bank_ctrl i_irq_bank_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    #1 busValid = 0;
  endtask

  task automatic cpWr(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    cpValid = 1; cpWrite = 1; cpIndex = i; cpWdata = d;
    @(negedge clk);
    cpValid = 0; cpWrite = 0;
  endtask

  task automatic cpRd(input logic [3:0] i, output logic [31:0] d);
    @(negedge clk);
    cpValid = 1; cpWrite = 0; cpIndex = i;
    #1 d = cpRdata;
    #1 cpValid = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R10 reset state
    busRd(8'h04, rd); chk("R10 enable", rd, 0);
    busRd(8'hA4, rd); chk("R10 steer", rd, 0);
    busRd(8'h10, rd); chk("R10 pending", rd, 0);
    busRd(8'h1C, rd); chk("R10 prio", rd, 0);
    chk("R10 outs", {29'd0, irqOut, fiqOut, wakeReq}, 0);
    busRd(8'h14, rd); chk("R5 idle reset", rd, 1);

    // R1 R3 R4 sweep: every source, every enable/steer combination
    for (int s = 0; s < 40; s++) begin
      logic       bk;
      logic [4:0] bt;
      bk = (s >= 32); bt = 5'(s & 31);
      srcLevel = 40'd1 << s;
      for (int st = 0; st < 2; st++) begin
        for (int mk = 0; mk < 2; mk++) begin
          if (s % 2 == 0) begin
            busWr(bk ? 8'hA0 : 8'h04, 32'(mk) << bt);
            busWr(bk ? 8'hA4 : 8'h08, 32'(st) << bt);
          end else begin
            cpWr(bk ? 4'h7 : 4'h1, 32'(mk) << bt);   // R8 index writes
            cpWr(bk ? 4'h8 : 4'h2, 32'(st) << bt);
          end
          settle();
          chk("R4 fiqOut", 32'(fiqOut), 32'(mk & st));
          chk("R4 irqOut", 32'(irqOut), 32'(mk & (1 - st)));
          busRd(bk ? 8'h9C : 8'h00, rd);
          chk("R3 irq view", rd, 32'(mk & (1 - st)) << bt);
          busRd(bk ? 8'hA8 : 8'h0C, rd);
          chk("R3 fiq view", rd, 32'(mk & st) << bt);
          busRd(bk ? 8'hAC : 8'h10, rd);
          chk("R1 R2 raw", rd, 32'd1 << bt);
        end
      end
    end

    // R12 readback, R1 high bank width
    busWr(8'hA0, 32'hFFFF_FFFF); busRd(8'hA0, rd); chk("R1 R12 high enable", rd, 32'hFF);
    busWr(8'h04, 32'h1234_5678); busRd(8'h04, rd); chk("R12 low enable", rd, 32'h1234_5678);
    busWr(8'h08, 32'hCAFE_0001); busRd(8'h08, rd); chk("R12 low steer", rd, 32'hCAFE_0001);

    // R2 pending follows pin, writes ignored
    srcLevel = 40'hA5_0F0F_3C3C;
    settle();
    busWr(8'h10, 32'hFFFF_FFFF); busWr(8'hAC, 32'h0);
    busRd(8'h10, rd); chk("R2 raw low", rd, 32'h0F0F_3C3C);
    busRd(8'hAC, rd); chk("R2 raw high", rd, 32'hA5);
    srcLevel = '0;
    @(negedge clk); @(negedge clk);
    busRd(8'h10, rd); chk("R2 raw follows", rd, 0);

    // R7 priority entries
    for (int i = 0; i < 40; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      a = (i < 32) ? 8'(8'h1C + 4 * i) : 8'(8'hB0 + 4 * (i - 32));
      d = 32'hF5A5_A5E0 ^ (32'(i) * 32'h0101_0107);
      busWr(a, d);
      busRd(a, rd);
      chk("R7 prio", rd, d & 32'h8000_003F);
    end
    busRd(8'h1C, rd); chk("R7 prio 0 kept", rd, 32'hF5A5_A5E0 & 32'h8000_003F);

    // R9 undefined / unaligned
    busWr(8'h04, 32'h0000_00F0);
    busWr(8'hD0, 32'hFFFF_FFFF); busWr(8'h06, 32'hFFFF_FFFF);
    busRd(8'h04, rd); chk("R9 write ignored", rd, 32'h0000_00F0);
    busRd(8'hD0, rd); chk("R9 undef read", rd, 0);
    busRd(8'h05, rd); chk("R9 unaligned read", rd, 0);
    busRd(8'hFC, rd); chk("R9 top read", rd, 0);

    // R11 highest-priority passthrough
    busRd(8'h18, rd); chk("R11 bus", rd, 32'h8003_0005);
    hpValue = 32'h0000_8027;
    cpRd(4'h5, rd); chk("R11 index", rd, 32'h0000_8027);

    // R8 index map aliases the bus map
    busWr(8'h04, 32'h00FF_00FF); busWr(8'h08, 32'h0F0F_0F0F);
    busWr(8'hA0, 32'h3C); busWr(8'hA4, 32'h0F);
    srcLevel = 40'h5A_FFFF_FFFF;
    settle();
    begin
      logic [7:0] amap [11];
      amap = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h18,
               8'h9C, 8'hA0, 8'hA4, 8'hA8, 8'hAC};
      for (int k = 0; k < 11; k++) begin
        cpRd(4'(k), rd); busRd(amap[k], rd2);
        chk("R8 alias", rd, rd2);
      end
    end
    cpRd(4'hB, rd); chk("R8 bad index read", rd, 0);
    cpWr(4'hC, 32'h0); busRd(8'h04, rd); chk("R8 bad index write", rd, 32'h00FF_00FF);
    cpWr(4'h4, 32'h0); busRd(8'h10, rd); chk("R8 raw write ignored", rd, 32'hFFFF_FFFF);
    // simultaneous writes: bus wins
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = 8'h04; busWdata = 32'h1;
    cpValid = 1; cpWrite = 1; cpIndex = 4'h1; cpWdata = 32'h2;
    @(negedge clk);
    busValid = 0; busWrite = 0; cpValid = 0; cpWrite = 0;
    busRd(8'h04, rd); chk("R8 bus precedence", rd, 32'h1);

    // R5 R6 idle wake
    busWr(8'h04, 0); busWr(8'hA0, 0);
    srcLevel = 40'h01_0000_0000;
    coreHalted = 1;
    settle();
    chk("R6 masked no wake", 32'(wakeReq), 0);
    busWr(8'h14, 32'h0); busRd(8'h14, rd); chk("R5 idle set read", rd, 0);
    settle();
    chk("R6 idle wake", 32'(wakeReq), 1);
    chk("R4 masked no irq", 32'(irqOut | fiqOut), 0);
    coreHalted = 0;
    settle();
    chk("R6 not halted", 32'(wakeReq), 0);
    coreHalted = 1;
    busWr(8'h14, 32'h1); busRd(8'h14, rd); chk("R5 idle clear read", rd, 1);
    settle();
    chk("R6 idle cleared", 32'(wakeReq), 0);
    busWr(8'hA0, 32'h1);
    settle();
    chk("R6 enabled wake", 32'(wakeReq), 1);
    coreHalted = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule